// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target that gives a bus master access to a small bank of byte registers held inside the block. The block samples SCL and SDA on its own system clock and finds START, repeated START and STOP conditions. It answers one fixed 7-bit device address. It acknowledges by pulling SDA low through an open-drain enable output.

A write transaction carries a register-address byte first, and that byte loads an internal pointer. Every data byte after it is stored at the pointer, and the pointer then steps on by one. To read, the master sets the pointer with a short write and then issues a repeated START with the read bit set. The block then returns bytes from the pointer, stepping after each one, until the master answers with a NACK. The pointer wraps from the last register back to register 0. The pointer keeps its value across STOP and repeated START, so a read that does not first set the pointer continues from where the last access stopped.

Top module: `i2c_regfile_target`

## Requirements
- R1: The first byte after a START or repeated START holds the 7-bit device address in its upper seven bits, sent MSB first, and the direction bit in bit 0: 0 selects write and 1 selects read. The block responds only when the address equals the parameter `DEV_ADDR` (default 7'h5C).
- R2: The block acknowledges a matching address byte, and every byte it receives in a write, by holding SDA low (`sda_oe_o` = 1) for the whole high period of the ninth SCL pulse.
- R3: While SCL is high, an SDA fall is a START and an SDA rise is a STOP. Either condition is recognised in any state. A repeated START restarts address matching, and a STOP returns the block to idle with SDA released.
- R4: The first byte of a write transaction loads the pointer from its low `$clog2(NUM_REGS)` bits (bits [2:0] for the default of 8 registers). A value at or above `NUM_REGS` loads 0.
- R5: Each later byte of a write is stored in the register the pointer selects, and the pointer then advances by one.
- R6: After a matching address byte with the direction bit set to 1, the block sends the selected register MSB first. It changes the bit on SDA only while SCL is low.
- R7: After each byte it sends, the pointer advances by one. A master ACK (SDA low on the ninth clock) makes the block send the next register. A NACK makes the block release SDA until the next START or STOP.
- R8: After an address that does not match, the block leaves SDA released for every bit until the next START or STOP. The bytes that follow change no register and leave the pointer unchanged.
- R9: The pointer steps from register `NUM_REGS`-1 to register 0, in both writes and reads.
- R10: STOP and repeated START keep the pointer value. A read that comes without a pointer write continues at the pointer left by the previous access.
- R11: `sda_oe_o` changes only in the cycle after a detected SCL fall, START or STOP, so SDA stays stable while SCL is high.
- R12: Reset releases SDA. Reset sets register i to `RST_BASE` + i (default `RST_BASE` 8'h30) and sets the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (the wired-AND level) |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
A wrong pointer or a missed write cannot be seen right away. It shows up at the ports only when a later read returns a wrong byte. For that reason every write in the bench is followed by a read-back through a repeated START, or through a fresh START after a STOP. An error in the state machine shows up within one byte: an acknowledge goes missing or appears where it should not, an address that does not match is answered, or SDA moves while SCL is high. The bench therefore checks the ninth bit of every byte and checks that SDA stays stable across every SCL high phase.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } tgt_state_e;

  localparam int unsigned LINE_CNT = 2;
  localparam int unsigned LINE_SCL = 0;
  localparam int unsigned LINE_SDA = 1;
endpackage

// File: rtl/i2c_bus_frontend.sv
module i2c_bus_frontend
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_lvl_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned DEPTH = SYNC_STAGES + 1;

  logic [LINE_CNT-1:0] raw;
  logic [LINE_CNT-1:0] lvl, prv;

  assign raw[LINE_SCL] = scl_i;
  assign raw[LINE_SDA] = sda_i;

  for (genvar g = 0; g < LINE_CNT; g++) begin : g_line
    logic [DEPTH-1:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= '1;  // idle bus level
      else         pipe <= {pipe[DEPTH-2:0], raw[g]};
    end
    assign lvl[g] = pipe[DEPTH-2];
    assign prv[g] = pipe[DEPTH-1];
  end

  assign scl_rise_o = lvl[LINE_SCL] & ~prv[LINE_SCL];
  assign scl_fall_o = ~lvl[LINE_SCL] & prv[LINE_SCL];
  assign sda_lvl_o  = lvl[LINE_SDA];
  // SDA edge while SCL is held high on both samples
  assign start_o = lvl[LINE_SCL] & prv[LINE_SCL] & ~lvl[LINE_SDA] & prv[LINE_SDA];
  assign stop_o  = lvl[LINE_SCL] & prv[LINE_SCL] & lvl[LINE_SDA] & ~prv[LINE_SDA];
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int unsigned NUM_REGS = 8,
  parameter logic [7:0]  RST_BASE = 8'h30,
  localparam int unsigned PTR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptr_load_i,
  input  logic [7:0]       ptr_val_i,
  input  logic             ptr_inc_i,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_REGS - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_cand;
  logic [7:0]       regs [NUM_REGS];

  assign ptr_cand = ptr_val_i[PTR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (ptr_load_i) begin
      ptr_q <= (32'(ptr_cand) >= NUM_REGS) ? '0 : ptr_cand;
    end else if (ptr_inc_i) begin
      ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            regs[g] <= RST_BASE + 8'(g);
      else if (wr_i && ptr_q == PTR_W'(g))    regs[g] <= wdata_i;
    end
  end

  assign rdata_o = regs[ptr_q];
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h5C,
  parameter int unsigned NUM_REGS = 8,
  parameter logic [7:0]  RST_BASE = 8'h30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int unsigned PTR_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [3:0]  CNT_FULL = 4'd8;

  logic scl_rise, scl_fall, sda_lvl, start_det, stop_det;
  tgt_state_e state_q;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh, rdata;
  logic       sda_oe_q, rw_q, first_q, mack_q;
  logic [PTR_W-1:0] ptr;
  logic       byte_end, ptr_load, wr_en, ptr_inc;

  i2c_bus_frontend #(.SYNC_STAGES(2)) u_fe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .sda_lvl_o  (sda_lvl),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  assign byte_end = scl_fall && (bit_cnt == CNT_FULL) && !start_det && !stop_det;
  assign ptr_load = byte_end && (state_q == ST_RX) && first_q;
  assign wr_en    = byte_end && (state_q == ST_RX) && !first_q;
  assign ptr_inc  = wr_en || (byte_end && (state_q == ST_TX));

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .RST_BASE(RST_BASE)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ptr_load_i (ptr_load),
    .ptr_val_i  (rx_sh),
    .ptr_inc_i  (ptr_inc),
    .wr_i       (wr_en),
    .wdata_i    (rx_sh),
    .rdata_o    (rdata),
    .ptr_o      (ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      sda_oe_q <= 1'b0;
      rw_q     <= 1'b0;
      first_q  <= 1'b0;
      mack_q   <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_ADDR;
      bit_cnt  <= '0;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[6:0], sda_lvl};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_end) begin
            bit_cnt <= '0;
            if (state_q == ST_ADDR) begin
              if (rx_sh[7:1] == DEV_ADDR) begin
                state_q  <= ST_ADDR_ACK;
                sda_oe_q <= 1'b1;
                rw_q     <= rx_sh[0];
                first_q  <= 1'b1;
              end else begin
                state_q <= ST_SKIP;
              end
            end else begin
              state_q  <= ST_RX_ACK;
              sda_oe_q <= 1'b1;
              first_q  <= 1'b0;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              state_q  <= ST_TX;
              tx_sh    <= rdata;
              sda_oe_q <= ~rdata[7];
            end else begin
              state_q  <= ST_RX;
              sda_oe_q <= 1'b0;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            state_q  <= ST_RX;
            sda_oe_q <= 1'b0;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_end) begin
            bit_cnt  <= '0;
            sda_oe_q <= 1'b0;
            state_q  <= ST_TX_ACK;
          end else if (scl_fall) begin
            tx_sh    <= {tx_sh[6:0], 1'b0};
            sda_oe_q <= ~tx_sh[6];
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_q  <= ST_TX;
              tx_sh    <= rdata;
              sda_oe_q <= ~rdata[7];
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned PTR_W    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_oe_o,
  input tgt_state_e       state_q,
  input logic [PTR_W-1:0] ptr
);
  p_oe_after_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> $past(scl_fall || start_det || stop_det));

  p_stop_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state_q == ST_IDLE) && !sda_oe_o);

  p_start_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det && !stop_det) |=> (state_q == ST_ADDR) && !sda_oe_o);

  p_skip_released_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> !sda_oe_o);

  p_rx_ack_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RX_ACK || state_q == ST_ADDR_ACK) |-> sda_oe_o);

  p_ptr_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ptr) < NUM_REGS);
endmodule

bind i2c_regfile_target i2c_tgt_chk #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe_o  (sda_oe_o),
  .state_q   (state_q),
  .ptr       (ptr)
);

// File: tb/i2c_regfile_target_test.sv
module i2c_regfile_target_test;
  localparam logic [6:0] DEV   = 7'h5C;
  localparam logic [6:0] OTHER = 7'h5D;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;

  int checks = 0;
  int failures = 0;
  logic [7:0] mdl [8];

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_q[$];
  event       obs_ev;

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_regfile_target uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(obs_ev);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] o, e;
        string t;
        o = obs_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(o === e, t, o, e);
      end
    end
  end

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic b, output logic r, output logic stable);
    logic r1, r2;
    sda_m = b; qw();
    scl_m = 1'b1; qw();
    r1 = sda_bus; qw();
    r2 = sda_bus;
    scl_m = 1'b0; qw();
    r = r1;
    stable = (r1 === r2);
  endtask

  task automatic do_start();
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b0; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b1; qw();
  endtask

  // expected ack: 0 = ACK, 1 = NACK
  task automatic wbyte(input logic [7:0] d, input logic exp_nack, input string tag);
    logic r, st, all_st;
    all_st = 1'b1;
    exp_q.push_back({7'd0, exp_nack});
    tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(d[i], r, st);
      all_st &= st;
    end
    bit_cycle(1'b1, r, st);
    all_st &= st;
    obs_q.push_back({7'd0, r});
    ->obs_ev;
    check(all_st, "R11 sda stable while scl high (write byte)", {7'd0, all_st}, 8'd1);
  endtask

  task automatic rbyte(input logic ack, input logic [7:0] e, input string tag);
    logic r, st, all_st;
    logic [7:0] d;
    all_st = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, r, st);
      d[i] = r;
      all_st &= st;
    end
    bit_cycle(~ack, r, st);
    obs_q.push_back(d);
    ->obs_ev;
    check(all_st, "R11/R6 sda stable while scl high (read byte)", {7'd0, all_st}, 8'd1);
  endtask

  initial begin
    repeat (3000000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 8'h30 + 8'(i);
    repeat (4) @(negedge clk);
    check(sda_oe === 1'b0, "R12 sda released in reset", {7'd0, sda_oe}, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sda_oe === 1'b0, "R12 sda released after reset", {7'd0, sda_oe}, 8'd0);

    // R12/R6/R7: reset values via burst read from 0, wrap back to 0
    do_start();
    wbyte({DEV, 1'b0}, 1'b0, "R1 address+write ack");
    wbyte(8'h00, 1'b0, "R2 pointer byte ack");
    do_start();
    wbyte({DEV, 1'b1}, 1'b0, "R6 address+read ack");
    for (int i = 0; i < 8; i++) rbyte(i < 7, mdl[i], "R12/R7 burst read of reset values");
    do_stop();

    // R5/R9: burst write across the wrap, then read back
    do_start();
    wbyte({DEV, 1'b0}, 1'b0, "R1 address ack");
    wbyte(8'h06, 1'b0, "R4 pointer ack");
    wbyte(8'hAA, 1'b0, "R5 data ack");
    wbyte(8'hBB, 1'b0, "R5 data ack");
    wbyte(8'hCC, 1'b0, "R9 data ack after wrap");
    do_stop();
    mdl[6] = 8'hAA; mdl[7] = 8'hBB; mdl[0] = 8'hCC;
    do_start();
    wbyte({DEV, 1'b0}, 1'b0, "R1 address ack");
    wbyte(8'h06, 1'b0, "R4 pointer ack");
    do_start();
    wbyte({DEV, 1'b1}, 1'b0, "R6 read address ack");
    rbyte(1'b1, mdl[6], "R5 burst write readback");
    rbyte(1'b1, mdl[7], "R5 burst write readback");
    rbyte(1'b0, mdl[0], "R9 pointer wrap readback");
    do_stop();

    // R8: non-matching address is ignored
    do_start();
    wbyte({OTHER, 1'b0}, 1'b1, "R8 foreign address not acked");
    wbyte(8'h02, 1'b1, "R8 byte not acked");
    wbyte(8'h55, 1'b1, "R8 byte not acked");
    do_stop();
    do_start();
    wbyte({DEV, 1'b0}, 1'b0, "R1 address ack");
    wbyte(8'h02, 1'b0, "R4 pointer ack");
    do_start();
    wbyte({DEV, 1'b1}, 1'b0, "R6 read address ack");
    rbyte(1'b0, mdl[2], "R8 register unchanged");
    do_stop();

    // R10: pointer survives STOP
    do_start();
    wbyte({DEV, 1'b0}, 1'b0, "R1 address ack");
    wbyte(8'h04, 1'b0, "R4 pointer ack");
    wbyte(8'h11, 1'b0, "R5 data ack");
    do_stop();
    mdl[4] = 8'h11;
    do_start();
    wbyte({DEV, 1'b1}, 1'b0, "R10 read address ack");
    rbyte(1'b0, mdl[5], "R10 read continues at kept pointer");
    do_stop();
    do_start();
    wbyte({DEV, 1'b1}, 1'b0, "R10 read address ack");
    rbyte(1'b0, mdl[6], "R7 pointer advanced by NACKed read");
    do_stop();
    check(sda_oe === 1'b0, "R3 sda released after stop", {7'd0, sda_oe}, 8'd0);

    // R4: out-of-width pointer byte keeps low bits
    do_start();
    wbyte({DEV, 1'b0}, 1'b0, "R1 address ack");
    wbyte(8'h0D, 1'b0, "R4 pointer ack");
    wbyte(8'h77, 1'b0, "R5 data ack");
    do_stop();
    mdl[5] = 8'h77;
    do_start();
    wbyte({DEV, 1'b0}, 1'b0, "R1 address ack");
    wbyte(8'h05, 1'b0, "R4 pointer ack");
    do_start();
    wbyte({DEV, 1'b1}, 1'b0, "R6 read address ack");
    rbyte(1'b0, mdl[5], "R4 pointer from low bits");
    do_stop();

    // R3: repeated start to foreign address restarts matching
    do_start();
    wbyte({DEV, 1'b0}, 1'b0, "R1 address ack");
    wbyte(8'h01, 1'b0, "R4 pointer ack");
    do_start();
    wbyte({OTHER, 1'b1}, 1'b1, "R3 repeated start foreign address");
    do_stop();
    do_start();
    wbyte({DEV, 1'b1}, 1'b0, "R3 read address ack");
    rbyte(1'b0, mdl[1], "R3/R10 pointer kept across repeated start");
    do_stop();

    repeat (4) @(negedge clk);
    ->obs_ev;
    #1;
    check(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule